// File: doc/BRIEF.md
# Signed significand adder/subtractor

This block adds or subtracts two significands that an earlier stage has already aligned to a common exponent. Each operand arrives as a magnitude with its own sign, together with a select that asks for a sum or a difference. The block decides whether the operation is an effective addition or an effective subtraction. It then runs the work through one two's-complement adder. Negating the second operand costs only a bitwise inversion and an asserted carry-in, so no separate incrementer is needed.

When an effective subtraction goes negative, the block does not negate the sum afterwards. The adder also produces a second result: the complement of the raw sum plus the inverted carry-in. That second result equals the positive magnitude, so the block takes it and flips the sign.

The result is registered once. It gives the magnitude, a carry-out for a later one-bit right normalization, the result sign, a zero flag, and a low guard field. When the carry is set, that low field is already folded for the shift, so no sticky information is lost.

Top module: `fpas_mant_addsub`

## Requirements
- R1: The operation is an effective subtraction when the operand signs differ and `in_sub`=0, or when the signs are equal and `in_sub`=1. Otherwise it is an effective addition.
- R2: `out_mag` equals the low SIG_W bits of |(±A) + (±B)|, where each operand is negated if its sign bit is 1 and B is additionally negated when `in_sub`=1.
- R3: `out_carry` equals bit SIG_W of that absolute value. It can be 1 only after an effective addition.
- R4: For a non-zero result, `out_neg` is the sign of A. It is inverted when the magnitude of B exceeds that of A under effective subtraction.
- R5: An exact zero from an effective subtraction has `out_neg`=0. An effective addition of two zeros keeps the sign of A.
- R6: With `out_carry`=0, `out_low` equals `out_mag[GRS_W-1:0]`. With `out_carry`=1, `out_low` equals {`out_mag[GRS_W:2]`, `out_mag[1]`|`out_mag[0]`}, which is the guard field after a one-bit right shift with the shifted-out bit kept as sticky.
- R7: `out_zero` is 1 exactly when `out_mag` and `out_carry` are both zero.
- R8: A result appears one clock edge after the edge that samples `in_valid`=1. `out_valid` is that sampled `in_valid` delayed by one edge.
- R9: An edge with `in_valid`=0 leaves `out_mag`, `out_carry`, `out_neg`, `out_low` and `out_zero` unchanged.
- R10: While reset is held, and until the first valid input, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands on the inputs are to be processed |
| in_a_sig | input | MAN_W+GRS_W (27) | Aligned significand A with guard bits |
| in_a_neg | input | 1 | Sign of A, 1 = negative |
| in_b_sig | input | MAN_W+GRS_W (27) | Aligned significand B with guard bits |
| in_b_neg | input | 1 | Sign of B, 1 = negative |
| in_sub | input | 1 | 0 = A+B, 1 = A-B |
| out_valid | output | 1 | Result registers hold a new result |
| out_mag | output | MAN_W+GRS_W (27) | Result magnitude, low SIG_W bits |
| out_carry | output | 1 | Magnitude bit SIG_W, used for right normalization |
| out_neg | output | 1 | Result sign |
| out_low | output | GRS_W (3) | Guard field, shift-folded when the carry is set |
| out_zero | output | 1 | Result is exactly zero |

## Verification
Every result field is due on the first clock edge after the edge that samples the operands with `in_valid` high. On edges that sample `in_valid` low, the fields must keep their values while `out_valid` drops.

The bench drives inputs on the falling edge. It updates its reference prediction just after the rising edge, and it compares every output on the following falling edge, so each comparison lines up with the one register stage. Idle cycles carry random junk operands, which shows that the hold behaviour does not depend on the data inputs.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

  typedef enum logic {
    FPAS_OP_ADD = 1'b0,
    FPAS_OP_SUB = 1'b1
  } fpas_op_e;

  // Effective subtraction: operand signs disagree after folding in the op select.
  function automatic logic fpas_eff_sub(input logic a_neg, input logic b_neg,
                                        input fpas_op_e op);
    return a_neg ^ b_neg ^ (op == FPAS_OP_SUB);
  endfunction

endpackage

// File: rtl/fpas_opprep.sv
module fpas_opprep
  import fpas_pkg::*;
#(
  parameter int SIG_W = 27
) (
  input  logic [SIG_W-1:0] a_sig,
  input  logic             a_neg,
  input  logic [SIG_W-1:0] b_sig,
  input  logic             b_neg,
  input  logic             sub_sel,
  output logic [SIG_W:0]   a_ext,
  output logic [SIG_W:0]   b_ext,
  output logic             cin,
  output logic             eff_sub
);

  fpas_op_e op;

  always_comb begin
    op      = sub_sel ? FPAS_OP_SUB : FPAS_OP_ADD;
    eff_sub = fpas_eff_sub(a_neg, b_neg, op);
    a_ext   = {1'b0, a_sig};
    // Only B is ever negated: invert its zero-extended form, carry-in supplies the +1.
    b_ext   = eff_sub ? ~{1'b0, b_sig} : {1'b0, b_sig};
    cin     = eff_sub;
  end

endmodule

// File: rtl/fpas_dual_adder.sv
module fpas_dual_adder #(
  parameter int SIG_W = 27
) (
  input  logic [SIG_W:0]   a_ext,
  input  logic [SIG_W:0]   b_ext,
  input  logic             cin,
  output logic [SIG_W:0]   sum_pos,
  output logic [SIG_W-1:0] sum_cmp
);

  logic [SIG_W:0] raw;

  always_comb begin
    raw     = a_ext + b_ext;
    // First result: (A+B)+cin
    sum_pos = raw + {{SIG_W{1'b0}}, cin};
    // Second result: ~(A+B)+!cin, the magnitude when the first is negative
    sum_cmp = ~raw[SIG_W-1:0] + {{(SIG_W-1){1'b0}}, ~cin};
  end

endmodule

// File: rtl/fpas_select.sv
module fpas_select #(
  parameter int SIG_W = 27,
  parameter int GRS_W = 3
) (
  input  logic [SIG_W:0]   sum_pos,
  input  logic [SIG_W-1:0] sum_cmp,
  input  logic             eff_sub,
  input  logic             a_neg,
  output logic [SIG_W-1:0] mag,
  output logic             carry,
  output logic             neg,
  output logic [GRS_W-1:0] low,
  output logic             zero
);

  logic use_cmp;

  always_comb begin
    use_cmp = eff_sub & sum_pos[SIG_W];
    mag     = use_cmp ? sum_cmp : sum_pos[SIG_W-1:0];
    carry   = ~eff_sub & sum_pos[SIG_W];
    zero    = (mag == '0) & ~carry;
    if (eff_sub && zero) begin
      neg = 1'b0;
    end else begin
      neg = a_neg ^ use_cmp;
    end
    if (carry) begin
      low = {mag[GRS_W:2], mag[1] | mag[0]};
    end else begin
      low = mag[GRS_W-1:0];
    end
  end

endmodule

// File: rtl/fpas_mant_addsub.sv
module fpas_mant_addsub #(
  parameter int MAN_W = 24,
  parameter int GRS_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [MAN_W+GRS_W-1:0] in_a_sig,
  input  logic                   in_a_neg,
  input  logic [MAN_W+GRS_W-1:0] in_b_sig,
  input  logic                   in_b_neg,
  input  logic                   in_sub,
  output logic                   out_valid,
  output logic [MAN_W+GRS_W-1:0] out_mag,
  output logic                   out_carry,
  output logic                   out_neg,
  output logic [GRS_W-1:0]       out_low,
  output logic                   out_zero
);

  localparam int SIG_W = MAN_W + GRS_W;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic [SIG_W:0]   a_ext, b_ext;
  logic             cin, eff_sub;
  logic [SIG_W:0]   sum_pos;
  logic [SIG_W-1:0] sum_cmp;
  logic [SIG_W-1:0] mag_d;
  logic             carry_d, neg_d, zero_d;
  logic [GRS_W-1:0] low_d;

  fpas_opprep #(.SIG_W(SIG_W)) u_prep (
    .a_sig   (in_a_sig),
    .a_neg   (in_a_neg),
    .b_sig   (in_b_sig),
    .b_neg   (in_b_neg),
    .sub_sel (in_sub),
    .a_ext   (a_ext),
    .b_ext   (b_ext),
    .cin     (cin),
    .eff_sub (eff_sub)
  );

  fpas_dual_adder #(.SIG_W(SIG_W)) u_add (
    .a_ext   (a_ext),
    .b_ext   (b_ext),
    .cin     (cin),
    .sum_pos (sum_pos),
    .sum_cmp (sum_cmp)
  );

  fpas_select #(.SIG_W(SIG_W), .GRS_W(GRS_W)) u_sel (
    .sum_pos (sum_pos),
    .sum_cmp (sum_cmp),
    .eff_sub (eff_sub),
    .a_neg   (in_a_neg),
    .mag     (mag_d),
    .carry   (carry_d),
    .neg     (neg_d),
    .low     (low_d),
    .zero    (zero_d)
  );

  logic             valid_q, valid_n;
  logic [SIG_W-1:0] mag_q, mag_n;
  logic             carry_q, carry_n, neg_q, neg_n, zero_q, zero_n;
  logic [GRS_W-1:0] low_q, low_n;

  always_comb begin
    valid_n = in_valid;
    mag_n   = mag_q;
    carry_n = carry_q;
    neg_n   = neg_q;
    low_n   = low_q;
    zero_n  = zero_q;
    if (in_valid) begin
      mag_n   = mag_d;
      carry_n = carry_d;
      neg_n   = neg_d;
      low_n   = low_d;
      zero_n  = zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      mag_q   <= '0;
      carry_q <= 1'b0;
      neg_q   <= 1'b0;
      low_q   <= '0;
      zero_q  <= 1'b0;
    end else begin
      valid_q <= valid_n;
      mag_q   <= mag_n;
      carry_q <= carry_n;
      neg_q   <= neg_n;
      low_q   <= low_n;
      zero_q  <= zero_n;
    end
  end

  assign out_valid = valid_q;
  assign out_mag   = mag_q;
  assign out_carry = carry_q;
  assign out_neg   = neg_q;
  assign out_low   = low_q;
  assign out_zero  = zero_q;

endmodule

// File: rtl/fpas_mant_addsub_chk.sv
module fpas_mant_addsub_chk #(
  parameter int MAN_W = 24,
  parameter int GRS_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_a_neg,
  input logic                   in_b_neg,
  input logic                   in_sub,
  input logic                   out_valid,
  input logic [MAN_W+GRS_W-1:0] out_mag,
  input logic                   out_carry,
  input logic                   out_neg,
  input logic [GRS_W-1:0]       out_low,
  input logic                   out_zero
);

  logic eff_sub_in;
  assign eff_sub_in = in_a_neg ^ in_b_neg ^ in_sub;

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mag) && $stable(out_carry) && $stable(out_neg)
                   && $stable(out_low) && $stable(out_zero)));

  p_carry_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_sub_in) |=> !out_carry);

  p_zero_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero && $past(eff_sub_in)) |-> !out_neg);

  p_zero_def_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> (out_mag == '0 && !out_carry));

  p_low_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_carry) |-> (out_low == out_mag[GRS_W-1:0]));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r10: assert (!out_valid);
    end
  end

endmodule

bind fpas_mant_addsub fpas_mant_addsub_chk #(.MAN_W(MAN_W), .GRS_W(GRS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_a_neg  (in_a_neg),
  .in_b_neg  (in_b_neg),
  .in_sub    (in_sub),
  .out_valid (out_valid),
  .out_mag   (out_mag),
  .out_carry (out_carry),
  .out_neg   (out_neg),
  .out_low   (out_low),
  .out_zero  (out_zero)
);

// File: tb/fpas_mant_addsub_test.sv
module fpas_mant_addsub_test;

  localparam int MAN_W = 24;
  localparam int GRS_W = 3;
  localparam int SIG_W = MAN_W + GRS_W;
  localparam longint MASK = (64'd1 << SIG_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [SIG_W-1:0] in_a_sig, in_b_sig;
  logic             in_a_neg, in_b_neg, in_sub;
  logic             out_valid;
  logic [SIG_W-1:0] out_mag;
  logic             out_carry, out_neg, out_zero;
  logic [GRS_W-1:0] out_low;

  int checks = 0;
  int errors = 0;

  fpas_mant_addsub #(.MAN_W(MAN_W), .GRS_W(GRS_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a_sig  (in_a_sig),
    .in_a_neg  (in_a_neg),
    .in_b_sig  (in_b_sig),
    .in_b_neg  (in_b_neg),
    .in_sub    (in_sub),
    .out_valid (out_valid),
    .out_mag   (out_mag),
    .out_carry (out_carry),
    .out_neg   (out_neg),
    .out_low   (out_low),
    .out_zero  (out_zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference state: what the outputs should show now
  logic         e_valid = 1'b0;
  longint       e_mag   = 0;
  logic         e_carry = 1'b0, e_neg = 1'b0, e_zero = 1'b0;
  longint       e_low   = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag_data);
    chk("R8", "out_valid", longint'(out_valid), longint'(e_valid));
    chk(tag_data == "" ? "R2" : tag_data, "out_mag", longint'(out_mag), e_mag);
    chk(tag_data == "" ? "R3" : tag_data, "out_carry", longint'(out_carry), longint'(e_carry));
    chk(tag_data == "" ? "R4/R5" : tag_data, "out_neg", longint'(out_neg), longint'(e_neg));
    chk(tag_data == "" ? "R6" : tag_data, "out_low", longint'(out_low), e_low);
    chk(tag_data == "" ? "R7" : tag_data, "out_zero", longint'(out_zero), longint'(e_zero));
  endtask

  // One clock: drive at the falling edge, model update after the rising edge,
  // compare at the next falling edge.
  task automatic step(input logic v, input longint a, input logic an,
                      input longint b, input logic bn, input logic sb);
    longint va, vb, r, m;
    logic   effsub, p_neg;
    longint p_low;
    in_valid = v;
    in_a_sig = a[SIG_W-1:0];
    in_a_neg = an;
    in_b_sig = b[SIG_W-1:0];
    in_b_neg = bn;
    in_sub   = sb;
    // R1: effective subtraction when the signed contributions differ in sign
    effsub = an ^ bn ^ sb;
    va = an ? -a : a;
    vb = (bn ^ sb) ? -b : b;
    r  = va + vb;
    m  = (r < 0) ? -r : r;
    if (r < 0)       p_neg = 1'b1;
    else if (r > 0)  p_neg = 1'b0;
    else             p_neg = effsub ? 1'b0 : an;
    if (((m >> SIG_W) & 1) != 0)
      p_low = (((m >> 2) & ((64'd1 << (GRS_W - 1)) - 1)) << 1) | (((m >> 1) | m) & 1);
    else
      p_low = m & ((64'd1 << GRS_W) - 1);
    @(posedge clk);
    #1;
    e_valid = v;
    if (v) begin
      e_mag   = m & MASK;
      e_carry = ((m >> SIG_W) & 1) != 0;
      e_neg   = p_neg;
      e_low   = p_low;
      e_zero  = (m == 0);
    end
    @(negedge clk);
    compare_all(v ? "" : "R9");
  endtask

  task automatic idle_junk();
    step(1'b0, longint'($urandom) & MASK, 1'($urandom), longint'($urandom) & MASK,
         1'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R8)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_a_sig = '0; in_b_sig = '0;
    in_a_neg = 1'b0; in_b_neg = 1'b0; in_sub = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R10");

    // R1/R2: plain add, plain subtract, add with opposite signs
    step(1'b1, 100, 1'b0, 23, 1'b0, 1'b0);
    step(1'b1, 100, 1'b0, 23, 1'b0, 1'b1);
    step(1'b1, 100, 1'b0, 23, 1'b1, 1'b0);
    // R4: B larger under effective subtraction flips the sign
    step(1'b1, 5, 1'b0, 900, 1'b0, 1'b1);
    step(1'b1, 5, 1'b1, 900, 1'b0, 1'b0);
    step(1'b1, 5, 1'b1, 900, 1'b1, 1'b1);
    // R5: exact zeros
    step(1'b1, 12345, 1'b1, 12345, 1'b1, 1'b1);
    step(1'b1, 777, 1'b0, 777, 1'b1, 1'b0);
    step(1'b1, 0, 1'b1, 0, 1'b1, 1'b0);
    step(1'b1, 0, 1'b1, 0, 1'b0, 1'b0);
    // R3/R6: carry-out with sticky folding
    step(1'b1, MASK, 1'b0, MASK, 1'b0, 1'b0);
    step(1'b1, MASK, 1'b1, 1, 1'b1, 1'b0);
    step(1'b1, (64'd1 << (SIG_W - 1)) | 1, 1'b0, 64'd1 << (SIG_W - 1), 1'b0, 1'b0);
    step(1'b1, (64'd1 << (SIG_W - 1)) | 2, 1'b1, (64'd1 << (SIG_W - 1)) | 1, 1'b0, 1'b1);
    // R9: idle cycles with junk inputs must hold
    for (int i = 0; i < 4; i++) idle_junk();

    // near-equal magnitudes, both orders
    for (int i = 0; i < 300; i++) begin
      longint a, d;
      a = longint'($urandom) & MASK;
      d = longint'($urandom_range(0, 2));
      step(1'b1, a, 1'($urandom), (a + d) & MASK, 1'($urandom), 1'($urandom));
      step(1'b1, (a + d) & MASK, 1'($urandom), a, 1'($urandom), 1'($urandom));
    end

    // random operands with random gaps
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 5) == 0) idle_junk();
      step(1'b1, longint'($urandom) & MASK, 1'($urandom),
           longint'($urandom) & MASK, 1'($urandom), 1'($urandom));
    end
    idle_junk();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule